// File: doc/BRIEF.md
# UART command and status controller

This block is the control plane that sits beside a UART's transmit and receive engines. Software writes a byte-wide command register. Its bits set the transmitter and receiver enable levels and fire single-cycle actions: resetting either engine, starting or ending a line break, clearing the sticky line-error flags and restarting the receive time-out. The block also keeps the receive status. A byte-loaded pulse from the deserializer sets a ready flag, and a read of the receive holding location clears it. Error pulses from the deserializer latch into sticky overrun, framing and parity flags.

A 16-bit divisor, written as a low and a high byte, divides the system clock into a one-cycle enable at sixteen times the serial bit rate. The receive time-out counts whole bit periods of that enable while the receiver is on, and raises a sticky flag when a programmed number of bit periods has passed.

Register bus map (3-bit address): 0 command (write-only, reads 0), 1 status (read-only), 2 receive holding byte (read-only), 3 divisor low, 4 divisor high, 5 time-out length in bit periods.

Top module: `uart_ctl_stat`

## Requirements
- R1: After reset, all registers and flags are 0: `rx_en_o`, `tx_en_o`, `brk_o`, `stat_o` are 0, addresses 3, 4 and 5 read 0, and `tick16_o` stays low.
- R2: Every write to address 0 loads the receiver enable from data bit 7 and the transmitter enable from data bit 5. A read of address 0 returns 0. Addresses 3, 4 and 5 read back the last value written.
- R3: A write to address 0 with bit 3 set pulses `tx_rst_o`, and one with bit 2 set pulses `rx_rst_o`. Each pulse is high for exactly the one cycle after the write.
- R4: Command bit 0 sets the break level `brk_o` and command bit 1 clears it. When both are 1 in the same write, the break is cleared. `brk_o` also appears as status bit 5.
- R5: Pulses on `ovr_err_i`, `frm_err_i` and `par_err_i` set sticky status bits 1, 2 and 3. A command write with bit 6 set clears all three, but a pulse that arrives in the same cycle as the clear keeps its flag set.
- R6: `rx_loaded_i` sets status bit 0. A read of address 2 returns `rx_byte_i` and clears bit 0. A load in the same cycle as that read leaves bit 0 set.
- R7: With divisor D = {address 4, address 3} of at least 2, `tick16_o` is a one-cycle pulse every D cycles. The first pulse comes D cycles after the last divisor write.
- R8: A divisor of 0 or 1 produces no `tick16_o` pulses. A write to either divisor byte restarts the tick phase.
- R9: With time-out length L (address 5) nonzero and the receiver enabled, status bit 4 sets after 16·L ticks counted from the last restart. With L = 0 it never sets.
- R10: The time-out count pauses while the receiver is disabled and resumes when it is enabled again.
- R11: Command bit 4 clears status bit 4 and the time-out count. Without it, status bit 4 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after a read |
| rx_byte_i | input | 8 | Byte held by the deserializer |
| rx_loaded_i | input | 1 | Deserializer loaded a new byte |
| ovr_err_i | input | 1 | Overrun error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| par_err_i | input | 1 | Parity error pulse |
| rx_en_o | output | 1 | Receiver enable level |
| tx_en_o | output | 1 | Transmitter enable level |
| rx_rst_o | output | 1 | One-cycle receive engine reset |
| tx_rst_o | output | 1 | One-cycle transmit engine reset |
| brk_o | output | 1 | Transmit break level |
| tick16_o | output | 1 | 16x oversampling enable pulse |
| stat_o | output | 6 | Status flags: 0 ready, 1 overrun, 2 framing, 3 parity, 4 time-out, 5 break |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions. One is an error pulse landing in the same cycle as the line-error clear. Another is a byte load landing in the same cycle as the holding-register read. The stimulus drives both inputs on one falling edge so they meet at a single rising edge. The time-out pause needs the receiver switched off in the middle of a count. The bench therefore restarts the count with the receiver disabled, waits much longer than the period, and then re-enables the receiver without a restart to show that the count resumes. All 256 command values are swept with the break level predicted from the previous state, and divisors 0 to 9 plus one high-byte value are swept for tick latency and period.

// File: rtl/uart_cs_pkg.sv
package uart_cs_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIVL = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIVH = 3'd4;
  localparam logic [ADDR_W-1:0] A_TMO  = 3'd5;

  // field order mirrors command byte bit order 7..0
  typedef struct packed {
    logic rx_en;
    logic err_clr;
    logic tx_en;
    logic tmo_rst;
    logic tx_rst;
    logic rx_rst;
    logic brk_stop;
    logic brk_start;
  } cmd_t;

  localparam int unsigned ST_RDY = 0;
  localparam int unsigned ST_OVR = 1;
  localparam int unsigned ST_FRM = 2;
  localparam int unsigned ST_PAR = 3;
  localparam int unsigned ST_TMO = 4;
  localparam int unsigned ST_BRK = 5;
  localparam int unsigned ST_W   = 6;
  localparam int unsigned N_ERR  = 3;
endpackage

// File: rtl/uart_cs_cmd.sv
module uart_cs_cmd
  import uart_cs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_i,
  input  cmd_t   cmd_i,
  output cmd_t   stb_o,
  output logic   rx_en_o,
  output logic   tx_en_o,
  output logic   rx_rst_o,
  output logic   tx_rst_o,
  output logic   brk_o
);
  cmd_t stb;
  assign stb   = wr_i ? cmd_i : '0;
  assign stb_o = stb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_o  <= 1'b0;
      tx_en_o  <= 1'b0;
      rx_rst_o <= 1'b0;
      tx_rst_o <= 1'b0;
      brk_o    <= 1'b0;
    end else begin
      rx_rst_o <= stb.rx_rst;
      tx_rst_o <= stb.tx_rst;
      if (wr_i) begin
        rx_en_o <= cmd_i.rx_en;
        tx_en_o <= cmd_i.tx_en;
      end
      // stop outranks start
      if (stb.brk_stop)       brk_o <= 1'b0;
      else if (stb.brk_start) brk_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_cs_baud.sv
module uart_cs_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_wr_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             run;

  assign run    = div_i > DIV_W'(1);
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (div_wr_i || !run) begin
        cnt_q <= '0;
      end else if (cnt_q == div_i - DIV_W'(1)) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_cs_tmo.sv
module uart_cs_tmo #(
  parameter int unsigned OSR   = 16,
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [TMO_W-1:0] len_i,
  output logic             expired_o
);
  localparam int unsigned SUB_W = (OSR > 1) ? $clog2(OSR) : 1;

  logic [SUB_W-1:0] sub_q;
  logic [TMO_W-1:0] bits_q;
  logic             exp_q;
  logic             hit;

  assign hit       = (len_i != '0) && (bits_q >= len_i);
  assign expired_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      bits_q <= '0;
      exp_q  <= 1'b0;
    end else if (restart_i) begin
      sub_q  <= '0;
      bits_q <= '0;
      exp_q  <= 1'b0;
    end else begin
      if (run_i && tick_i && !hit) begin
        if (sub_q == SUB_W'(OSR - 1)) begin
          sub_q  <= '0;
          bits_q <= bits_q + TMO_W'(1);
        end else begin
          sub_q <= sub_q + SUB_W'(1);
        end
      end
      if (hit) exp_q <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_cs_stat.sv
module uart_cs_stat
  import uart_cs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loaded_i,
  input  logic             rd_hold_i,
  input  logic [N_ERR-1:0] err_i,
  input  logic             err_clr_i,
  output logic             rdy_o,
  output logic [N_ERR-1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdy_o <= 1'b0;
    else if (loaded_i)  rdy_o <= 1'b1;
    else if (rd_hold_i) rdy_o <= 1'b0;
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        err_o[g] <= 1'b0;
      else if (err_i[g])  err_o[g] <= 1'b1;
      else if (err_clr_i) err_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_ctl_stat.sv
module uart_ctl_stat
  import uart_cs_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16,
  parameter int unsigned TMO_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              rx_loaded_i,
  input  logic              ovr_err_i,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              brk_o,
  output logic              tick16_o,
  output logic [ST_W-1:0]   stat_o
);
  localparam int unsigned DIV_W = 2 * DATA_W;

  logic              wr_cmd, wr_divl, wr_divh, wr_tmo, rd_hold;
  logic [DATA_W-1:0] divl_q, divh_q;
  logic [TMO_W-1:0]  tmo_len_q;
  logic [DIV_W-1:0]  div_q;
  cmd_t              stb;
  logic              rdy, tmo_exp;
  logic [N_ERR-1:0]  err_flags;
  logic [DATA_W-1:0] rdata_q;

  assign wr_cmd  = wr_en_i && (addr_i == A_CMD);
  assign wr_divl = wr_en_i && (addr_i == A_DIVL);
  assign wr_divh = wr_en_i && (addr_i == A_DIVH);
  assign wr_tmo  = wr_en_i && (addr_i == A_TMO);
  assign rd_hold = rd_en_i && (addr_i == A_RXD);
  assign div_q   = {divh_q, divl_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      divl_q    <= '0;
      divh_q    <= '0;
      tmo_len_q <= '0;
    end else begin
      if (wr_divl) divl_q    <= wdata_i;
      if (wr_divh) divh_q    <= wdata_i;
      if (wr_tmo)  tmo_len_q <= TMO_W'(wdata_i);
    end
  end

  uart_cs_cmd i_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_cmd),
    .cmd_i   (cmd_t'(wdata_i[7:0])),
    .stb_o   (stb),
    .rx_en_o (rx_en_o),
    .tx_en_o (tx_en_o),
    .rx_rst_o(rx_rst_o),
    .tx_rst_o(tx_rst_o),
    .brk_o   (brk_o)
  );

  uart_cs_baud #(.DIV_W(DIV_W)) i_baud (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (div_q),
    .div_wr_i(wr_divl || wr_divh),
    .tick_o  (tick16_o)
  );

  uart_cs_tmo #(.OSR(OSR), .TMO_W(TMO_W)) i_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_o),
    .run_i    (rx_en_o),
    .restart_i(stb.tmo_rst),
    .len_i    (tmo_len_q),
    .expired_o(tmo_exp)
  );

  uart_cs_stat i_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .loaded_i (rx_loaded_i),
    .rd_hold_i(rd_hold),
    .err_i    ({par_err_i, frm_err_i, ovr_err_i}),
    .err_clr_i(stb.err_clr),
    .rdy_o    (rdy),
    .err_o    (err_flags)
  );

  always_comb begin
    stat_o         = '0;
    stat_o[ST_RDY] = rdy;
    stat_o[ST_OVR] = err_flags[0];
    stat_o[ST_FRM] = err_flags[1];
    stat_o[ST_PAR] = err_flags[2];
    stat_o[ST_TMO] = tmo_exp;
    stat_o[ST_BRK] = brk_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        A_STAT:  rdata_q <= DATA_W'(stat_o);
        A_RXD:   rdata_q <= rx_byte_i;
        A_DIVL:  rdata_q <= divl_q;
        A_DIVH:  rdata_q <= divh_q;
        A_TMO:   rdata_q <= DATA_W'(tmo_len_q);
        default: rdata_q <= '0;
      endcase
    end
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/uart_cs_chk.sv
module uart_cs_chk
  import uart_cs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic              tx_rst_o,
  input logic              rx_rst_o,
  input logic              brk_o,
  input logic              tick16_o,
  input logic [ST_W-1:0]   stat_o,
  input logic [15:0]       div_i
);
  logic cmd_wr;
  assign cmd_wr = wr_en_i && (addr_i == A_CMD);

  p_cmd_reads_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_CMD) |=> (rdata_o == 8'h00));

  p_txrst_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_o |-> $past(cmd_wr && wdata_i[3]));

  p_rxrst_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |-> $past(cmd_wr && wdata_i[2]));

  p_brk_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_o) |-> $past(cmd_wr && wdata_i[0] && !wdata_i[1]));

  p_brk_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brk_o) |-> $past(cmd_wr && wdata_i[1]));

  p_par_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[ST_PAR]) |-> $past(cmd_wr && wdata_i[6]));

  p_rdy_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[ST_RDY]) |-> $past(rd_en_i && addr_i == A_RXD));

  p_tick_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick16_o |=> !tick16_o);

  p_no_tick_low_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i < 16'd2) |-> !tick16_o);

  p_tmo_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_o[ST_TMO]) |-> $past(cmd_wr && wdata_i[4]));
endmodule

bind uart_ctl_stat uart_cs_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .tx_rst_o(tx_rst_o),
  .rx_rst_o(rx_rst_o),
  .brk_o   (brk_o),
  .tick16_o(tick16_o),
  .stat_o  (stat_o),
  .div_i   (div_q)
);

// File: tb/test_uart_ctl_stat.sv
module test_uart_ctl_stat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rx_byte = '0;
  logic       rx_loaded = 1'b0, ovr_err = 1'b0, frm_err = 1'b0, par_err = 1'b0;
  logic       rx_en, tx_en, rx_rst, tx_rst, brk, tick;
  logic [5:0] stat;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_ctl_stat i_uart_ctl_stat (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rx_byte_i(rx_byte),
    .rx_loaded_i(rx_loaded), .ovr_err_i(ovr_err), .frm_err_i(frm_err),
    .par_err_i(par_err), .rx_en_o(rx_en), .tx_en_o(tx_en), .rx_rst_o(rx_rst),
    .tx_rst_o(tx_rst), .brk_o(brk), .tick16_o(tick), .stat_o(stat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles from now until tick is seen
  task automatic ticks_until(output int k);
    k = 0;
    while (!tick && k < 600) begin @(negedge clk); k++; end
  endtask

  task automatic tick_period(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick && k < 600);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_tb();
    end
  end

  initial begin
    logic [7:0] d;
    logic       brk_exp;
    int         k, cnt;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 rx_en", rx_en, 0);
    check("R1 tx_en", tx_en, 0);
    check("R1 brk", brk, 0);
    check("R1 stat", stat, 0);
    rd(3'd3, d); check("R1 divl", d, 0);
    rd(3'd4, d); check("R1 divh", d, 0);
    rd(3'd5, d); check("R1 tmo len", d, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (tick) cnt++; end
    check("R1 no tick", cnt, 0);

    // R2 readback
    wr(3'd5, 8'h00);
    wr(3'd3, 8'h5a); rd(3'd3, d); check("R2 divl readback", d, 8'h5a);
    wr(3'd4, 8'hc3); rd(3'd4, d); check("R2 divh readback", d, 8'hc3);
    wr(3'd0, 8'hff); rd(3'd0, d); check("R2 cmd reads zero", d, 0);
    wr(3'd0, 8'h02);

    // R2 R3 R4 exhaustive command sweep
    brk_exp = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] c;
      c = 8'(v);
      if (c[1]) brk_exp = 1'b0;
      else if (c[0]) brk_exp = 1'b1;
      wr(3'd0, c);
      check("R2 rx_en", rx_en, c[7]);
      check("R2 tx_en", tx_en, c[5]);
      check("R3 tx_rst pulse", tx_rst, c[3]);
      check("R3 rx_rst pulse", rx_rst, c[2]);
      check("R4 brk", brk, brk_exp);
      check("R4 stat brk", stat[5], brk_exp);
      @(negedge clk);
      check("R3 tx_rst one cycle", tx_rst, 0);
      check("R3 rx_rst one cycle", rx_rst, 0);
    end
    wr(3'd0, 8'h01); check("R4 start", brk, 1);
    wr(3'd0, 8'h03); check("R4 both stop wins", brk, 0);
    wr(3'd0, 8'h00);

    // R5 error flags
    @(negedge clk); ovr_err = 1'b1; @(negedge clk); ovr_err = 1'b0;
    check("R5 ovr set", stat[1], 1);
    @(negedge clk); frm_err = 1'b1; @(negedge clk); frm_err = 1'b0;
    check("R5 frm set", stat[2], 1);
    @(negedge clk); par_err = 1'b1; @(negedge clk); par_err = 1'b0;
    check("R5 par set", stat[3], 1);
    idle(5);
    check("R5 sticky", stat[3:1], 3'b111);
    wr(3'd0, 8'h40);
    check("R5 cleared", stat[3:1], 3'b000);
    @(negedge clk); frm_err = 1'b1; @(negedge clk); frm_err = 1'b0;
    @(negedge clk); par_err = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 8'h40;
    @(negedge clk); par_err = 1'b0; wr_en = 1'b0;
    check("R5 par pulse beats clear", stat[3], 1);
    check("R5 frm cleared", stat[2], 0);
    wr(3'd0, 8'h40);

    // R6 receive ready
    rx_byte = 8'ha5;
    @(negedge clk); rx_loaded = 1'b1; @(negedge clk); rx_loaded = 1'b0;
    check("R6 ready set", stat[0], 1);
    rd(3'd1, d); check("R6 status read", d, 8'h01);
    check("R6 status read keeps ready", stat[0], 1);
    rd(3'd2, d); check("R6 holding data", d, 8'ha5);
    check("R6 ready cleared", stat[0], 0);
    rx_byte = 8'h3c;
    @(negedge clk); rx_loaded = 1'b1; rd_en = 1'b1; addr = 3'd2;
    @(negedge clk); rx_loaded = 1'b0; rd_en = 1'b0;
    check("R6 load beats read", stat[0], 1);
    rd(3'd2, d); check("R6 second read clears", stat[0], 0);

    // R7 R8 divisor sweep
    for (int dv = 0; dv < 10; dv++) begin
      wr(3'd4, 8'h00);
      wr(3'd3, 8'(dv));
      if (dv < 2) begin
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (tick) cnt++; end
        check("R8 no tick low divisor", cnt, 0);
      end else begin
        ticks_until(k);  check("R7 first tick latency", k, dv);
        tick_period(k);  check("R7 tick period", k, dv);
        tick_period(k);  check("R7 tick period repeat", k, dv);
      end
    end
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h01);
    ticks_until(k); check("R7 high byte divisor", k, 256);
    tick_period(k); check("R7 high byte period", k, 256);
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h08);
    ticks_until(k);
    idle(3);
    wr(3'd3, 8'h08);
    ticks_until(k); check("R8 phase restart on write", k, 8);

    // R9 R10 R11 time-out, divisor 2 -> bit period 32 cycles
    wr(3'd3, 8'h02);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h90);
    idle(200); check("R9 zero length never expires", stat[4], 0);
    wr(3'd5, 8'h02);
    wr(3'd0, 8'h90);
    idle(40); check("R9 not yet expired", stat[4], 0);
    idle(40); check("R9 expired", stat[4], 1);
    wr(3'd0, 8'h80);
    idle(10); check("R11 flag sticky", stat[4], 1);
    wr(3'd0, 8'h90); check("R11 restart clears", stat[4], 0);
    wr(3'd0, 8'h10);
    idle(200); check("R10 paused while disabled", stat[4], 0);
    wr(3'd0, 8'h80);
    idle(40); check("R10 resumed not yet", stat[4], 0);
    idle(40); check("R10 resumed expires", stat[4], 1);
    rd(3'd1, d); check("R9 status bit4 readback", d[4], 1);

    done = 1;
    finish_tb();
  end
endmodule